// File: doc/BRIEF.md
# Boot Memory Remap Reset Controller

This block owns the program-space memory map of a small 8-bit microcontroller test computer and the reset line of its processor. After power-on the boot/loader ROM answers at program address 0x0000. Once the loader has placed fresh code in the code RAM, a remap request makes the block do two things on the same clock edge. It drives the processor reset active, and it swaps the program decode so that the code RAM answers at address 0x0000 while the ROM vanishes from program space. When the reset pulse ends, the processor starts fetching from address 0x0000 again and runs the downloaded code.

An external supervisor has two inputs of its own. One forces the same remap. The other reboots into the loader: it restores the ROM map with an identical reset pulse. Both act in any state, including the middle of a pulse already running. The pulse length is a parameter counted in clock cycles. Its default equals 10 ms at the default clock rate.

The controller is a three-state machine:
- `ST_LOADER_RUN`: the processor runs with the loader map.
- `ST_HOLD`: the processor is held in reset while the timer runs.
- `ST_APP_RUN`: the processor runs with the application map.

Transitions:
- `T_TRIG`: any state goes to `ST_HOLD` on any accepted request. The timer restarts and the requested map is stored.
- `T_DONE_LOADER`: `ST_HOLD` goes to `ST_LOADER_RUN` when the timer expires and the loader map is selected.
- `T_DONE_APP`: `ST_HOLD` goes to `ST_APP_RUN` when the timer expires and the application map is selected.
- `T_POR`: the asynchronous reset returns the block to `ST_LOADER_RUN` with the loader map.

Top module: `boot_remap_ctrl`

## Requirements
- R1: While `rst_n` is low, `cpu_rst` is 1. After `rst_n` rises the block is in `ST_LOADER_RUN` with the loader map and `cpu_rst` 0. Asserting `rst_n` low from the application map returns the block to the loader map.
- R2: A request captured at clock edge k makes `cpu_rst` 1 from edge k. The new map is decoded from that same edge.
- R3: With no further request, `cpu_rst` stays 1 for exactly `RST_CYCLES` clock cycles after the capturing edge, then returns to 0.
- R4: While the application map is selected, `rom_cs` is 0 for every address.
- R5: In the application map, `ram_cs` is 1 when `prog_sel` is 1 and `prog_addr` < 2^`RAM_AW` (default 0x8000). It is 0 above that.
- R6: In the loader map, `rom_cs` is 1 when `prog_sel` is 1 and `prog_addr` < 2^`ROM_AW` (default 0x1000). It is 0 above that, and `ram_cs` is always 0.
- R7: `sup_boot_req` selects the loader map with the same `RST_CYCLES` pulse, starting from any state including `ST_APP_RUN`.
- R8: A request captured during `ST_HOLD` restarts the full `RST_CYCLES` count from its own edge. The map it requests replaces the earlier one.
- R9: Requests captured in the same cycle are resolved by fixed priority: `sup_boot_req` first, then `sup_remap_req`, then `local_remap_req`.
- R10: The selected map changes only on an edge after which `cpu_rst` is 1. It never changes while the processor runs.
- R11: `rom_cs` and `ram_cs` are never 1 together, and both are 0 whenever `prog_sel` is 0.
- R12: `sup_remap_req` selects the application map with the same pulse, starting from `ST_LOADER_RUN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| local_remap_req | input | 1 | Remap request from the loader, selects the application map |
| sup_remap_req | input | 1 | Supervisor request, selects the application map |
| sup_boot_req | input | 1 | Supervisor reboot request, selects the loader map |
| prog_sel | input | 1 | Processor is doing a program-space access |
| prog_addr | input | ADDR_W | Program-space address |
| cpu_rst | output | 1 | Active-high processor reset |
| rom_cs | output | 1 | Boot/loader ROM chip-select |
| ram_cs | output | 1 | Code RAM chip-select |

## Verification
The assertions check four things on every cycle:
- the chip-selects never overlap and stay off without a program access;
- the ROM stays dark in the application map;
- the map never moves while the processor runs;
- every request raises the reset on the next cycle, reboot requests select the loader map, and a pulse never ends early or late relative to the last request.

Only the directed scenarios show the rest. These cover the actual address windows of each map, the pulse length measured at the pins, the restart of a pulse by a late request, and the outcome of requests colliding in one cycle.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;

    typedef enum logic [1:0] {
        ST_LOADER_RUN = 2'd0,
        ST_HOLD       = 2'd1,
        ST_APP_RUN    = 2'd2
    } state_t;

    typedef enum logic {
        MAP_LOADER = 1'b0,
        MAP_APP    = 1'b1
    } map_t;

endpackage

// File: rtl/remap_arbiter.sv
module remap_arbiter
    import boot_remap_pkg::*;
(
    input  logic local_remap_req,
    input  logic sup_remap_req,
    input  logic sup_boot_req,
    output logic trig,
    output map_t target
);

    always_comb begin
        trig   = sup_boot_req | sup_remap_req | local_remap_req;
        target = MAP_LOADER;
        if (sup_boot_req) begin
            target = MAP_LOADER;
        end else if (sup_remap_req) begin
            target = MAP_APP;
        end else if (local_remap_req) begin
            target = MAP_APP;
        end
    end

endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
    parameter int RST_CYCLES = 16,
    localparam int CNT_W = $clog2(RST_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(RST_CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/map_decode.sv
module map_decode
    import boot_remap_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ROM_AW = 12,
    parameter int RAM_AW = 15
) (
    input  map_t              map_sel,
    input  logic              prog_sel,
    input  logic [ADDR_W-1:0] prog_addr,
    output logic              rom_cs,
    output logic              ram_cs
);

    logic in_rom_win;
    logic in_ram_win;

    generate
        if (ROM_AW < ADDR_W) begin : g_rom_part
            assign in_rom_win = (prog_addr[ADDR_W-1:ROM_AW] == '0);
        end else begin : g_rom_full
            assign in_rom_win = 1'b1;
        end
        if (RAM_AW < ADDR_W) begin : g_ram_part
            assign in_ram_win = (prog_addr[ADDR_W-1:RAM_AW] == '0);
        end else begin : g_ram_full
            assign in_ram_win = 1'b1;
        end
    endgenerate

    always_comb begin
        rom_cs = prog_sel && (map_sel == MAP_LOADER) && in_rom_win;
        ram_cs = prog_sel && (map_sel == MAP_APP) && in_ram_win;
    end

endmodule

// File: rtl/boot_remap_ctrl.sv
module boot_remap_ctrl
    import boot_remap_pkg::*;
#(
    parameter int CLK_HZ     = 200_000_000,
    parameter int HOLD_MS    = 10,
    parameter int RST_CYCLES = (CLK_HZ / 1000) * HOLD_MS,
    parameter int ADDR_W     = 16,
    parameter int ROM_AW     = 12,
    parameter int RAM_AW     = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              local_remap_req,
    input  logic              sup_remap_req,
    input  logic              sup_boot_req,
    input  logic              prog_sel,
    input  logic [ADDR_W-1:0] prog_addr,
    output logic              cpu_rst,
    output logic              rom_cs,
    output logic              ram_cs
);

    state_t state_q, state_d;
    map_t   map_q, map_d;
    logic   trig;
    map_t   target;
    logic   hold_done;

    remap_arbiter u_arb (
        .local_remap_req (local_remap_req),
        .sup_remap_req   (sup_remap_req),
        .sup_boot_req    (sup_boot_req),
        .trig            (trig),
        .target          (target)
    );

    hold_timer #(
        .RST_CYCLES (RST_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (trig),
        .done  (hold_done)
    );

    // Next state: T_TRIG wins from any state; T_DONE_* leave ST_HOLD.
    always_comb begin
        state_d = state_q;
        map_d   = map_q;
        if (trig) begin
            state_d = ST_HOLD;
            map_d   = target;
        end else begin
            unique case (state_q)
                ST_LOADER_RUN: state_d = ST_LOADER_RUN;
                ST_APP_RUN:    state_d = ST_APP_RUN;
                ST_HOLD: begin
                    if (hold_done) begin
                        state_d = (map_q == MAP_APP) ? ST_APP_RUN : ST_LOADER_RUN;
                    end
                end
                default:       state_d = ST_LOADER_RUN;
            endcase
        end
    end

    // State register (T_POR on rst_n).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOADER_RUN;
            map_q   <= MAP_LOADER;
        end else begin
            state_q <= state_d;
            map_q   <= map_d;
        end
    end

    // Outputs.
    always_comb begin
        cpu_rst = !rst_n || (state_q == ST_HOLD);
    end

    map_decode #(
        .ADDR_W (ADDR_W),
        .ROM_AW (ROM_AW),
        .RAM_AW (RAM_AW)
    ) u_dec (
        .map_sel   (map_q),
        .prog_sel  (prog_sel),
        .prog_addr (prog_addr),
        .rom_cs    (rom_cs),
        .ram_cs    (ram_cs)
    );

endmodule

// File: rtl/boot_remap_chk.sv
module boot_remap_chk #(
    parameter int RST_CYCLES = 16,
    localparam int CW = $clog2(RST_CYCLES + 2)
) (
    input logic clk,
    input logic rst_n,
    input logic local_remap_req,
    input logic sup_remap_req,
    input logic sup_boot_req,
    input logic prog_sel,
    input logic cpu_rst,
    input logic rom_cs,
    input logic ram_cs,
    input logic map_app
);

    logic          any_req;
    logic [CW-1:0] since_q;

    assign any_req = local_remap_req | sup_remap_req | sup_boot_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (any_req) begin
            since_q <= CW'(1);
        end else if (since_q != '0 && since_q <= CW'(RST_CYCLES)) begin
            since_q <= since_q + 1'b1;
        end
    end

    // R11
    cs_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_cs && ram_cs));

    // R11
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_sel |-> (!rom_cs && !ram_cs));

    // R4
    rom_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        map_app |-> !rom_cs);

    // R10
    map_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(map_app) |-> cpu_rst);

    // R2
    req_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> cpu_rst);

    // R9
    boot_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sup_boot_req |=> !map_app);

    // R3
    pulse_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q != '0 && since_q < CW'(RST_CYCLES)) |=> cpu_rst);

    // R3
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rst && !any_req && since_q == CW'(RST_CYCLES)) |=> !cpu_rst);

endmodule

bind boot_remap_ctrl boot_remap_chk #(
    .RST_CYCLES (RST_CYCLES)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .local_remap_req (local_remap_req),
    .sup_remap_req   (sup_remap_req),
    .sup_boot_req    (sup_boot_req),
    .prog_sel        (prog_sel),
    .cpu_rst         (cpu_rst),
    .rom_cs          (rom_cs),
    .ram_cs          (ram_cs),
    .map_app         (map_q)
);

// File: tb/tb_boot_remap_ctrl.sv
module tb_boot_remap_ctrl;

    localparam int N  = 16;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          local_remap_req = 1'b0;
    logic          sup_remap_req = 1'b0;
    logic          sup_boot_req = 1'b0;
    logic          prog_sel = 1'b0;
    logic [AW-1:0] prog_addr = '0;
    logic          cpu_rst, rom_cs, ram_cs;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    boot_remap_ctrl #(
        .RST_CYCLES (N),
        .ADDR_W     (AW),
        .ROM_AW     (12),
        .RAM_AW     (15)
    ) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .local_remap_req (local_remap_req),
        .sup_remap_req   (sup_remap_req),
        .sup_boot_req    (sup_boot_req),
        .prog_sel        (prog_sel),
        .prog_addr       (prog_addr),
        .cpu_rst         (cpu_rst),
        .rom_cs          (rom_cs),
        .ram_cs          (ram_cs)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic probe(input logic [AW-1:0] a, input logic sel,
                         input bit exp_rom, input bit exp_ram, input string req);
        prog_addr = a;
        prog_sel  = sel;
        #0.5;
        check(rom_cs == exp_rom, {req, " rom_cs"}, int'(rom_cs), int'(exp_rom));
        check(ram_cs == exp_ram, {req, " ram_cs"}, int'(ram_cs), int'(exp_ram));
        prog_sel = 1'b0;
    endtask

    // Drive requests for one cycle; returns at the negedge after the capturing edge.
    task automatic fire(input bit loc, input bit srm, input bit sbt);
        @(negedge clk);
        local_remap_req = loc;
        sup_remap_req   = srm;
        sup_boot_req    = sbt;
        @(negedge clk);
        local_remap_req = 1'b0;
        sup_remap_req   = 1'b0;
        sup_boot_req    = 1'b0;
    endtask

    task automatic pulse_len(output int n);
        n = 0;
        while (cpu_rst && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int n;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(cpu_rst == 1'b1, "R1 reset held", int'(cpu_rst), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(cpu_rst == 1'b0, "R1 released", int'(cpu_rst), 0);
        probe(16'h0000, 1'b1, 1'b1, 1'b0, "R1 R6 loader at 0");
        probe(16'h0FFF, 1'b1, 1'b1, 1'b0, "R6 rom top");
        probe(16'h1000, 1'b1, 1'b0, 1'b0, "R6 above rom");
        probe(16'h0000, 1'b0, 1'b0, 1'b0, "R11 no prog_sel");
        n = 0;
    endtask

    task automatic t_local_remap();
        int n;
        fire(1'b1, 1'b0, 1'b0);
        check(cpu_rst == 1'b1, "R2 reset on trigger", int'(cpu_rst), 1);
        // R10: map swapped while reset is already active
        probe(16'h0000, 1'b1, 1'b0, 1'b1, "R2 R10 ram at 0 in hold");
        pulse_len(n);
        check(n == N, "R3 pulse length", n, N);
        probe(16'h0000, 1'b1, 1'b0, 1'b1, "R5 ram at 0");
        probe(16'h0FFF, 1'b1, 1'b0, 1'b1, "R4 rom hidden");
        probe(16'hF000, 1'b1, 1'b0, 1'b0, "R4 rom hidden high");
        probe(16'h7FFF, 1'b1, 1'b0, 1'b1, "R5 ram top");
        probe(16'h8000, 1'b1, 1'b0, 1'b0, "R5 above ram");
        repeat (20) @(negedge clk);
        check(cpu_rst == 1'b0, "R10 run stays", int'(cpu_rst), 0);
        probe(16'h0000, 1'b1, 1'b0, 1'b1, "R10 map stable in run");
    endtask

    task automatic t_sup_boot();
        int n;
        fire(1'b0, 1'b0, 1'b1);
        check(cpu_rst == 1'b1, "R7 reset on reboot", int'(cpu_rst), 1);
        probe(16'h0000, 1'b1, 1'b1, 1'b0, "R7 rom back at 0");
        pulse_len(n);
        check(n == N, "R7 pulse length", n, N);
        probe(16'h0000, 1'b1, 1'b1, 1'b0, "R7 loader after pulse");
    endtask

    task automatic t_retrigger();
        int n;
        fire(1'b1, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        check(cpu_rst == 1'b1, "R8 still in hold", int'(cpu_rst), 1);
        fire(1'b0, 1'b0, 1'b1);
        pulse_len(n);
        check(n == N, "R8 restarted length", n, N);
        probe(16'h0000, 1'b1, 1'b1, 1'b0, "R8 newest map loader");
    endtask

    task automatic t_priority();
        int n;
        fire(1'b1, 1'b0, 1'b1);
        check(cpu_rst == 1'b1, "R9 pulse on collision", int'(cpu_rst), 1);
        probe(16'h0000, 1'b1, 1'b1, 1'b0, "R9 boot beats local");
        pulse_len(n);
        fire(1'b0, 1'b1, 1'b1);
        probe(16'h0000, 1'b1, 1'b1, 1'b0, "R9 boot beats sup remap");
        pulse_len(n);
        check(n == N, "R9 pulse length", n, N);
    endtask

    task automatic t_sup_remap();
        int n;
        fire(1'b0, 1'b1, 1'b0);
        check(cpu_rst == 1'b1, "R12 reset on sup remap", int'(cpu_rst), 1);
        pulse_len(n);
        check(n == N, "R12 pulse length", n, N);
        probe(16'h0000, 1'b1, 1'b0, 1'b1, "R12 app map");
    endtask

    task automatic t_por_from_app();
        @(negedge clk);
        rst_n = 1'b0;
        #0.5;
        check(cpu_rst == 1'b1, "R1 por in app", int'(cpu_rst), 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        probe(16'h0000, 1'b1, 1'b1, 1'b0, "R1 loader after por");
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_local_remap();
        t_sup_boot();
        t_retrigger();
        t_priority();
        t_sup_remap();
        t_por_from_app();
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule